// File: doc/BRIEF.md
# Stack-Top Exchange Bus Sequencer

This block swaps a 16-bit register pair with the word held at the top of a byte-wide stack in memory. It takes over once the opcode that asks for the swap has been fetched. It drives the memory bus with two read cycles, one idle clock and two write cycles. When the sequence ends it hands back the new pair value and raises a one-clock done flag. The read bytes are gathered in an internal temporary word. Its low half comes from the lower address and its high half from the address above it. The old pair is pushed back in the opposite address order: high byte to the upper address first, then low byte to the stack pointer address. During the sequence the stack pointer is raised by one and then brought back.

Time is counted in ticks. One tick is one clock of `clk` and equals half of a bus T-state. A bus cycle lasts three T-states, which is six ticks numbered 0 to 5. The idle clock lasts two ticks. All bus outputs are registered. They show a given tick of the sequence in the clock after the sequencer's state reaches that tick.

Top module: `stack_xchg_seq`

## Requirements
- R1: While `rst` is high, and after it falls until the first `start`, `mem_addr`, `mem_wdata`, `mem_req`, `mem_rd`, `mem_wr`, `sp_out`, `pair_out`, `busy` and `done` are all zero.
- R2: Sampled j clocks after the edge that accepts `start` (j = 1..28), the bus outputs show sequence tick s = j-1. Ticks 0-5 read at `sp_in`. Ticks 6-11 read at `sp_in`+1, which wraps modulo 2^ADDR_W.
- R3: When the sequence completes, `pair_out` equals {byte read at `sp_in`+1, byte read at `sp_in`}. Until then `pair_out` keeps its previous value.
- R4: Ticks 12-13 form an idle clock with no strobe and `mem_addr` = 0. `sp_out` becomes `sp_in`+1 from sample j = 14.
- R5: Ticks 14-19 write the high byte of `pair_in` at `sp_in`+1. Ticks 20-25 then write its low byte at `sp_in`. Outside bus cycles `mem_addr` and `mem_wdata` are 0.
- R6: Within each six-tick bus cycle, `mem_req` is high on ticks 1-4. `mem_rd` is high on ticks 1-4 of read cycles only. `mem_wr` is high on ticks 2-4 of write cycles only.
- R7: `sp_out` returns to `sp_in` from sample j = 20 and stays there. Inside a sequence it only ever moves by one step.
- R8: `busy` is high for samples j = 0..26. `done` is high only at sample j = 27, for exactly one clock.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The current sequence's addresses, data and stack pointer continue unchanged.
- R10: `mem_wdata` holds the same value for all six ticks of each write cycle, so it is stable around the whole write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one period per half T-state |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange; sampled only when idle |
| sp_in | input | ADDR_W | Stack pointer at start |
| pair_in | input | 2*BYTE_W | Register pair value to push |
| mem_rdata | input | BYTE_W | Read data from memory |
| mem_addr | output | ADDR_W | Registered bus address |
| mem_wdata | output | BYTE_W | Registered write data |
| mem_req | output | 1 | Memory request strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| sp_out | output | ADDR_W | Live stack pointer |
| pair_out | output | 2*BYTE_W | Register pair after exchange |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The exchange is run with stack pointers at zero, just below a 256-byte page boundary, at the top of the address space where SP+1 wraps to zero, at the midpoint, and at a spread of arithmetic values. Each run uses a different pair value. Memory contents are a function of the address, so a read from the wrong address, or a swap of the low and high halves of the temporary, shows up as a wrong result. Pair values with different high and low bytes show whether the writes go out in the wrong byte or address order. Every run after the first begins with a non-zero previous pair, so an early overwrite of the result becomes visible. Alternate runs inject a `start` with a different stack pointer partway through, which tells a correctly ignored request apart from a restart or a reload of SP.

// File: rtl/stack_xchg_pkg.sv
package stack_xchg_pkg;

  typedef enum logic [2:0] {
    XS_IDLE  = 3'd0,
    XS_RD_LO = 3'd1,
    XS_RD_HI = 3'd2,
    XS_GAP   = 3'd3,
    XS_WR_HI = 3'd4,
    XS_WR_LO = 3'd5,
    XS_FIN   = 3'd6
  } xstate_t;

  localparam int          TICK_W      = 3;
  localparam logic [2:0]  BUS_LAST    = 3'd5;
  localparam logic [2:0]  GAP_LAST    = 3'd1;
  localparam logic [2:0]  REQ_FIRST   = 3'd1;
  localparam logic [2:0]  REQ_LAST    = 3'd4;
  localparam logic [2:0]  WR_FIRST    = 3'd2;

endpackage

// File: rtl/stack_xchg_ctrl.sv
module stack_xchg_ctrl
  import stack_xchg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output xstate_t           state,
  output logic [TICK_W-1:0] tick,
  output logic              accept,
  output logic              latch_lo,
  output logic              latch_hi,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic              finish
);

  xstate_t           state_n;
  logic [TICK_W-1:0] tick_n;
  logic              bus_end;
  logic              gap_end;

  assign bus_end  = (tick == BUS_LAST);
  assign gap_end  = (tick == GAP_LAST);
  assign accept   = (state == XS_IDLE) && start;
  assign latch_lo = (state == XS_RD_LO) && bus_end;
  assign latch_hi = (state == XS_RD_HI) && bus_end;
  assign sp_inc   = (state == XS_GAP) && gap_end;
  assign sp_dec   = (state == XS_WR_HI) && bus_end;
  assign finish   = (state == XS_FIN);

  always_comb begin
    state_n = state;
    tick_n  = tick + TICK_W'(1);
    unique case (state)
      XS_IDLE: begin
        tick_n = '0;
        if (start) state_n = XS_RD_LO;
      end
      XS_RD_LO: if (bus_end) begin state_n = XS_RD_HI; tick_n = '0; end
      XS_RD_HI: if (bus_end) begin state_n = XS_GAP;   tick_n = '0; end
      XS_GAP:   if (gap_end) begin state_n = XS_WR_HI; tick_n = '0; end
      XS_WR_HI: if (bus_end) begin state_n = XS_WR_LO; tick_n = '0; end
      XS_WR_LO: if (bus_end) begin state_n = XS_FIN;   tick_n = '0; end
      XS_FIN: begin
        state_n = XS_IDLE;
        tick_n  = '0;
      end
      default: begin
        state_n = XS_IDLE;
        tick_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XS_IDLE;
      tick  <= '0;
    end else begin
      state <= state_n;
      tick  <= tick_n;
    end
  end

  assert_gap_short_R4: assert property (@(posedge clk) disable iff (rst)
    (state == XS_GAP) |-> (tick <= GAP_LAST));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (start && (state != XS_IDLE) && (state != XS_FIN)) |=> (state != XS_RD_LO) || (tick != '0));

  assert_accept_begins_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state == XS_RD_LO) && (tick == '0));

endmodule

// File: rtl/stack_xchg_datapath.sv
module stack_xchg_datapath #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busy,
  input  logic                accept,
  input  logic                latch_lo,
  input  logic                latch_hi,
  input  logic                sp_inc,
  input  logic                sp_dec,
  input  logic                finish,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [2*BYTE_W-1:0] pair_in,
  input  logic [BYTE_W-1:0]   rdata,
  output logic [ADDR_W-1:0]   sp_q,
  output logic [2*BYTE_W-1:0] push_q,
  output logic [2*BYTE_W-1:0] pair_q,
  output logic                done_q
);

  localparam int PAIR_W = 2 * BYTE_W;

  logic [PAIR_W-1:0] wz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      push_q <= '0;
      pair_q <= '0;
      wz_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        sp_q   <= sp_in;
        push_q <= pair_in;
      end else if (sp_inc) begin
        sp_q <= sp_q + ADDR_W'(1);
      end else if (sp_dec) begin
        sp_q <= sp_q - ADDR_W'(1);
      end
      if (latch_lo) wz_q[BYTE_W-1:0]      <= rdata;
      if (latch_hi) wz_q[PAIR_W-1:BYTE_W] <= rdata;
      if (finish)   pair_q                <= wz_q;
    end
  end

  assert_sp_unit_step_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && (sp_q != $past(sp_q))) |->
      ((sp_q == $past(sp_q) + ADDR_W'(1)) || (sp_q == $past(sp_q) - ADDR_W'(1))));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  assert_pair_held_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !finish) |=> $stable(pair_q));

endmodule

// File: rtl/stack_xchg_bus.sv
module stack_xchg_bus
  import stack_xchg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  xstate_t             state,
  input  logic [TICK_W-1:0]   tick,
  input  logic [ADDR_W-1:0]   sp_q,
  input  logic [2*BYTE_W-1:0] push_q,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_req,
  output logic                mem_rd,
  output logic                mem_wr
);

  logic              is_read;
  logic              is_write;
  logic              in_window;
  logic              in_wr_window;
  logic [ADDR_W-1:0] addr_n;
  logic [BYTE_W-1:0] wdata_n;

  assign is_read      = (state == XS_RD_LO) || (state == XS_RD_HI);
  assign is_write     = (state == XS_WR_HI) || (state == XS_WR_LO);
  assign in_window    = (tick >= REQ_FIRST) && (tick <= REQ_LAST);
  assign in_wr_window = (tick >= WR_FIRST) && (tick <= REQ_LAST);

  always_comb begin
    addr_n  = '0;
    wdata_n = '0;
    unique case (state)
      XS_RD_LO: addr_n = sp_q;
      XS_RD_HI: addr_n = sp_q + ADDR_W'(1);
      XS_WR_HI: begin
        addr_n  = sp_q;
        wdata_n = push_q[2*BYTE_W-1:BYTE_W];
      end
      XS_WR_LO: begin
        addr_n  = sp_q;
        wdata_n = push_q[BYTE_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_req   <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
    end else begin
      mem_addr  <= addr_n;
      mem_wdata <= wdata_n;
      mem_req   <= (is_read || is_write) && in_window;
      mem_rd    <= is_read && in_window;
      mem_wr    <= is_write && in_wr_window;
    end
  end

  assert_rd_wr_apart_R6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_wr_inside_req_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || mem_rd) |-> mem_req);

  assert_wr_after_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr) |-> $past(mem_req));

  assert_wdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> ($stable(mem_wdata) && $stable(mem_addr)));

endmodule

// File: rtl/stack_xchg_seq.sv
module stack_xchg_seq
  import stack_xchg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [ADDR_W-1:0]   sp_in,
  input  logic [2*BYTE_W-1:0] pair_in,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_req,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [ADDR_W-1:0]   sp_out,
  output logic [2*BYTE_W-1:0] pair_out,
  output logic                busy,
  output logic                done
);

  xstate_t             state;
  logic [TICK_W-1:0]   tick;
  logic                accept;
  logic                latch_lo;
  logic                latch_hi;
  logic                sp_inc;
  logic                sp_dec;
  logic                finish;
  logic [ADDR_W-1:0]   sp_q;
  logic [2*BYTE_W-1:0] push_q;

  assign busy   = (state != XS_IDLE);
  assign sp_out = sp_q;

  stack_xchg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .state    (state),
    .tick     (tick),
    .accept   (accept),
    .latch_lo (latch_lo),
    .latch_hi (latch_hi),
    .sp_inc   (sp_inc),
    .sp_dec   (sp_dec),
    .finish   (finish)
  );

  stack_xchg_datapath #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .accept   (accept),
    .latch_lo (latch_lo),
    .latch_hi (latch_hi),
    .sp_inc   (sp_inc),
    .sp_dec   (sp_dec),
    .finish   (finish),
    .sp_in    (sp_in),
    .pair_in  (pair_in),
    .rdata    (mem_rdata),
    .sp_q     (sp_q),
    .push_q   (push_q),
    .pair_q   (pair_out),
    .done_q   (done)
  );

  stack_xchg_bus #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .tick      (tick),
    .sp_q      (sp_q),
    .push_q    (push_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_req   (mem_req),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/tb_stack_xchg_seq.sv
module tb_stack_xchg_seq;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [15:0]       sp_in = '0;
  logic [15:0]       pair_in = '0;
  logic [7:0]        mem_rdata;
  logic [15:0]       mem_addr;
  logic [7:0]        mem_wdata;
  logic              mem_req, mem_rd, mem_wr;
  logic [15:0]       sp_out;
  logic [15:0]       pair_out;
  logic              busy, done;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_rd ? mem_byte(mem_addr) : 8'h00;

  stack_xchg_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut (
    .clk(clk), .rst(rst), .start(start), .sp_in(sp_in), .pair_in(pair_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_req(mem_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .sp_out(sp_out), .pair_out(pair_out), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int j, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s sample=%0d actual=%h expected=%h", tag, j, act, exp);
    end
  endtask

  task automatic run_xchg(input logic [15:0] sp, input logic [15:0] pr,
                          input logic inject, input logic [15:0] prev);
    logic [15:0] e_addr, e_sp, e_pair;
    logic [7:0]  e_wd;
    logic        e_req, e_rd, e_wr;
    int          s, t;
    @(negedge clk);
    start = 1'b1; sp_in = sp; pair_in = pr;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; sp_in = ~sp; pair_in = ~pr;
    for (int j = 1; j <= 28; j++) begin
      @(posedge clk);
      @(negedge clk);
      s = j - 1;
      e_addr = '0; e_wd = '0; e_req = 0; e_rd = 0; e_wr = 0;
      if (s < 6) begin
        t = s; e_addr = sp; e_req = (t >= 1 && t <= 4); e_rd = e_req;
      end else if (s < 12) begin
        t = s - 6; e_addr = sp + 16'd1; e_req = (t >= 1 && t <= 4); e_rd = e_req;
      end else if (s < 14) begin
        t = s - 12;
      end else if (s < 20) begin
        t = s - 14; e_addr = sp + 16'd1; e_wd = pr[15:8];
        e_req = (t >= 1 && t <= 4); e_wr = (t >= 2 && t <= 4);
      end else if (s < 26) begin
        t = s - 20; e_addr = sp; e_wd = pr[7:0];
        e_req = (t >= 1 && t <= 4); e_wr = (t >= 2 && t <= 4);
      end
      e_sp   = (j >= 14 && j < 20) ? sp + 16'd1 : sp;
      e_pair = (j >= 27) ? {mem_byte(sp + 16'd1), mem_byte(sp)} : prev;
      if (s < 12) chk(inject ? "R2 R9 read address" : "R2 read address", j, 32'(mem_addr), 32'(e_addr));
      else if (s < 14) chk("R4 idle address", j, 32'(mem_addr), 32'(e_addr));
      else chk(inject ? "R5 R9 write address" : "R5 write address", j, 32'(mem_addr), 32'(e_addr));
      chk("R5/R10 write data", j, 32'(mem_wdata), 32'(e_wd));
      chk("R6 mem_req", j, 32'(mem_req), 32'(e_req));
      chk("R6 mem_rd", j, 32'(mem_rd), 32'(e_rd));
      chk("R6 mem_wr", j, 32'(mem_wr), 32'(e_wr));
      if (j < 20) chk(inject ? "R4 R9 sp_out" : "R4 sp_out", j, 32'(sp_out), 32'(e_sp));
      else chk("R7 sp_out", j, 32'(sp_out), 32'(e_sp));
      chk("R3 pair_out", j, 32'(pair_out), 32'(e_pair));
      chk("R8 busy", j, 32'(busy), 32'(j <= 26));
      chk("R8 done", j, 32'(done), 32'(j == 27));
      if (inject && j == 10) begin
        start = 1'b1; sp_in = sp ^ 16'h0F0F; pair_in = pr ^ 16'hFFFF;
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog expired");
    bad++;
    total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic [15:0] sp_v, pr_v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset addr", 0, 32'(mem_addr), 0);
    chk("R1 reset strobes", 0, 32'({mem_req, mem_rd, mem_wr}), 0);
    chk("R1 reset wdata", 0, 32'(mem_wdata), 0);
    chk("R1 reset sp", 0, 32'(sp_out), 0);
    chk("R1 reset pair", 0, 32'(pair_out), 0);
    chk("R1 reset busy/done", 0, 32'({busy, done}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 0, 32'({mem_req, busy, done, sp_out}), 0);
    prev = 16'h0000;
    for (int k = 0; k < 20; k++) begin
      case (k)
        0: sp_v = 16'h0000;
        1: sp_v = 16'h00FE;
        2: sp_v = 16'hFFFF;
        3: sp_v = 16'h8000;
        4: sp_v = 16'h00FF;
        default: sp_v = 16'(k * 16'h1357 + 16'h0421);
      endcase
      pr_v = 16'(16'h4321 + k * 16'h0B17);
      run_xchg(sp_v, pr_v, k[0], prev);
      prev = {mem_byte(sp_v + 16'd1), mem_byte(sp_v)};
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule